// File: doc/BRIEF.md
# Code Memory Programming Controller

This block is the parallel programming port of an on-chip 4K x 8 code store, held here as a register array. An external programmer presents a 12-bit address, a data byte, a chip enable, four mode pins and an active-low program strobe. A high-voltage qualifier input stands in for the programming supply. Every write is self-timed: the strobe's rising edge starts it, and a ready/busy output reports its progress. While a byte write runs, a read of that address returns the byte being written with its top bit inverted, so a programmer can poll for completion.

Three nonvolatile lock bits form nested protection levels. The first blocks byte programming and freezes the external-access strap at the value seen during reset. The first two together blank verify reads. All three together withdraw permission to execute from external memory. The lock bits have no read path. Only a chip erase clears them, and that erase also returns every byte to FFh. Write and erase times are parameters in clock cycles.

Top module: `flash_prog_ctrl`

## Requirements
- R1: With mode 4'b1000, hv_i high and prog_n_i held low for at least ERASE_CYC clocks, the rising strobe clears all three lock bits and writes FFh to every address. busy_n_o stays low for exactly DEPTH cycles.
- R2: An erase strobe held low for fewer than ERASE_CYC clocks is ignored: busy_n_o stays high and the contents are unchanged.
- R3: With mode 4'b0111 and hv_i high, the rising strobe captures address and data. busy_n_o goes low in the next cycle and stays low for exactly WRITE_CYC cycles. The stored byte then becomes the old byte AND the new data, so a bit can only be cleared.
- R4: While a byte write is busy, a read of the captured address returns the written data with bit 7 inverted and bits 6:0 unchanged.
- R5: A strobe that arrives while busy_n_o is low is ignored. A write strobe with hv_i low is also ignored.
- R6: With mode 4'b0011, hv_i low and en_i high, data_o shows the stored byte one clock after the address is applied. In every mode that is not a read, data_o is FFh.
- R7: With mode 4'b0000 and hv_i low, data_o returns 1Eh at address 030h, 61h at 031h and FFh at 032h and at every other address.
- R8: Modes 4'b1111, 4'b1100 and 4'b1010 with hv_i high program lock bit 1, 2 and 3 respectively. Each is self-timed for WRITE_CYC cycles, like a byte write.
- R9: With lock bit 1 programmed, byte-write strobes are ignored: busy_n_o stays high and the array is unchanged. ea_eff_o then holds the value ea_pin_i had during reset; when lock bit 1 is not programmed, ea_eff_o follows ea_pin_i.
- R10: With lock bits 1 and 2 programmed, code reads return FFh. Signature reads are unaffected.
- R11: ext_exec_ok_o is low only while all three lock bits are programmed.
- R12: After reset, busy_n_o is high and data_o is FFh.
- R13: With en_i low, strobes are ignored and data_o reads FFh.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset of the controller; the array and lock bits keep their state |
| en_i | input | 1 | Interface enable |
| addr_i | input | ADDR_W | Byte address |
| data_i | input | 8 | Data to program |
| data_o | output | 8 | Registered read data |
| mode_i | input | 4 | Operation select |
| hv_i | input | 1 | Programming-voltage qualifier |
| prog_n_i | input | 1 | Program strobe, active low |
| ea_pin_i | input | 1 | External-access strap |
| busy_n_o | output | 1 | Ready (1) or busy (0) |
| ea_eff_o | output | 1 | Effective external-access level |
| ext_exec_ok_o | output | 1 | External execution permitted |

## Verification
Byte writes use complementary patterns (5Ah, A5h) so that the polled bit 7 differs in both directions. A second write over a non-blank byte separates AND-merging from plain overwrite. Erase strobes are tried on both sides of the hold threshold, and a strobe is sent during a busy write, to separate qualified starts from spurious ones. Reads with and without hv_i, with en_i low, and in signature mode are compared after each lock level, to show which lock disables which feature and that erase restores them all.

// File: rtl/fpc_pkg.sv
package fpc_pkg;
    localparam int NLOCK = 3;

    localparam logic [3:0] MODE_SIG   = 4'b0000;
    localparam logic [3:0] MODE_READ  = 4'b0011;
    localparam logic [3:0] MODE_WRITE = 4'b0111;
    localparam logic [3:0] MODE_ERASE = 4'b1000;
    localparam logic [3:0] MODE_LOCK3 = 4'b1010;
    localparam logic [3:0] MODE_LOCK2 = 4'b1100;
    localparam logic [3:0] MODE_LOCK1 = 4'b1111;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_WRITE = 2'd1,
        ST_LOCK  = 2'd2,
        ST_ERASE = 2'd3
    } state_e;
endpackage

// File: rtl/fpc_strobe.sv
// Detects the rising edge of the program strobe and measures how long
// it was held low while an erase was selected.
module fpc_strobe #(
    parameter int ERASE_CYC = 120000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic prog_n_i,
    input  logic erase_sel_i,
    output logic rise_o,
    output logic long_o
);
    localparam int LOW_W = $clog2(ERASE_CYC + 1);

    typedef struct packed {
        logic             prev;
        logic [LOW_W-1:0] low_cnt;
    } strobe_t;

    strobe_t s_d, s_q;

    always_comb begin
        s_d      = s_q;
        s_d.prev = prog_n_i;
        if (prog_n_i || !erase_sel_i) begin
            s_d.low_cnt = '0;
        end else if (s_q.low_cnt < LOW_W'(ERASE_CYC)) begin
            s_d.low_cnt = s_q.low_cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '{prev: 1'b1, low_cnt: '0};
        end else begin
            s_q <= s_d;
        end
    end

    assign rise_o = !s_q.prev && prog_n_i;
    assign long_o = (s_q.low_cnt >= LOW_W'(ERASE_CYC));
endmodule

// File: rtl/fpc_array.sv
// Nonvolatile code store: one write port, a read port for the interface
// and a second read port for merging a write with the old contents.
module fpc_array #(
    parameter int ADDR_W = 12,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              we_i,
    input  logic [ADDR_W-1:0] waddr_i,
    input  logic [DATA_W-1:0] wdata_i,
    input  logic [ADDR_W-1:0] raddr_i,
    output logic [DATA_W-1:0] rdata_o,
    input  logic [ADDR_W-1:0] caddr_i,
    output logic [DATA_W-1:0] cdata_o
);
    localparam int DEPTH = 1 << ADDR_W;

    logic [DATA_W-1:0] cells_q [DEPTH];

    always_ff @(posedge clk) begin
        if (we_i) begin
            cells_q[waddr_i] <= wdata_i;
        end
    end

    assign rdata_o = cells_q[raddr_i];
    assign cdata_o = cells_q[caddr_i];
endmodule

// File: rtl/fpc_lock.sv
// Lock bits (1 = programmed), nested protection decode and the
// external-access latch that is sampled while reset is held.
module fpc_lock
    import fpc_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic [NLOCK-1:0] set_i,
    input  logic             clr_i,
    input  logic             ea_pin_i,
    output logic             prog_lock_o,
    output logic             verify_lock_o,
    output logic             ext_exec_ok_o,
    output logic             ea_eff_o
);
    logic [NLOCK-1:0] lock_d, lock_q;
    logic             ea_d, ea_q;
    logic [NLOCK-1:0] level;

    always_comb begin
        lock_d = clr_i ? '0 : (lock_q | set_i);
        ea_d   = rst_n ? ea_q : ea_pin_i;
    end

    always_ff @(posedge clk) begin
        lock_q <= lock_d;
        ea_q   <= ea_d;
    end

    // Level k is active only when lock bits 0..k are all programmed.
    for (genvar k = 0; k < NLOCK; k++) begin : g_level
        assign level[k] = &lock_q[k:0];
    end

    assign prog_lock_o   = level[0];
    assign verify_lock_o = level[1];
    assign ext_exec_ok_o = !level[2];
    assign ea_eff_o      = lock_q[0] ? ea_q : ea_pin_i;

    // R9: once locked and out of reset, the strap value no longer moves
    assert_ea_frozen_R9: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && lock_q[0] && $past(lock_q[0])) |-> $stable(ea_eff_o));
endmodule

// File: rtl/fpc_readout.sv
// Registered read path: code verify with polling and lock blanking,
// and the signature bytes.
module fpc_readout
    import fpc_pkg::*;
#(
    parameter int          ADDR_W   = 12,
    parameter logic [11:0] SIG_BASE = 12'h030,
    parameter logic [7:0]  SIG0     = 8'h1E,
    parameter logic [7:0]  SIG1     = 8'h61
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en_i,
    input  logic              hv_i,
    input  logic [3:0]        mode_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [7:0]        arr_i,
    input  logic              poll_i,
    input  logic [ADDR_W-1:0] poll_addr_i,
    input  logic [7:0]        poll_data_i,
    input  logic              verify_lock_i,
    output logic [7:0]        data_o
);
    logic [7:0] data_d, data_q;

    always_comb begin
        data_d = 8'hFF;
        if (en_i && !hv_i) begin
            if (mode_i == MODE_READ) begin
                if (verify_lock_i) begin
                    data_d = 8'hFF;
                end else if (poll_i && addr_i == poll_addr_i) begin
                    data_d = {~poll_data_i[7], poll_data_i[6:0]};
                end else begin
                    data_d = arr_i;
                end
            end else if (mode_i == MODE_SIG) begin
                if (addr_i == ADDR_W'(SIG_BASE)) begin
                    data_d = SIG0;
                end else if (addr_i == ADDR_W'(SIG_BASE + 12'd1)) begin
                    data_d = SIG1;
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            data_q <= 8'hFF;
        end else begin
            data_q <= data_d;
        end
    end

    assign data_o = data_q;

    // R10: blanked verify never exposes array contents
    assert_verify_blank_R10: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(verify_lock_i) && $past(mode_i == MODE_READ)) |-> (data_o == 8'hFF));
endmodule

// File: rtl/flash_prog_ctrl.sv
module flash_prog_ctrl
    import fpc_pkg::*;
#(
    parameter int ADDR_W    = 12,
    parameter int WRITE_CYC = 24000,
    parameter int ERASE_CYC = 120000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [7:0]        data_i,
    output logic [7:0]        data_o,
    input  logic [3:0]        mode_i,
    input  logic              hv_i,
    input  logic              prog_n_i,
    input  logic              ea_pin_i,
    output logic              busy_n_o,
    output logic              ea_eff_o,
    output logic              ext_exec_ok_o
);
    localparam int DEPTH  = 1 << ADDR_W;
    localparam int WCNT_W = $clog2(WRITE_CYC + 1);

    typedef struct packed {
        state_e             st;
        logic [WCNT_W-1:0]  cnt;
        logic [ADDR_W-1:0]  addr;
        logic [7:0]         data;
        logic [NLOCK-1:0]   lsel;
        logic [ADDR_W-1:0]  sweep;
    } ctrl_t;

    ctrl_t c_d, c_q;

    logic              rise, long_low, erase_sel;
    logic              arr_we;
    logic [ADDR_W-1:0] arr_waddr;
    logic [7:0]        arr_wdata, arr_rdata, arr_cdata;
    logic [NLOCK-1:0]  lock_set;
    logic              lock_clr, prog_lock, verify_lock;

    assign erase_sel = hv_i && (mode_i == MODE_ERASE);

    fpc_strobe #(.ERASE_CYC(ERASE_CYC)) u_strobe (
        .clk         (clk),
        .rst_n       (rst_n),
        .prog_n_i    (prog_n_i),
        .erase_sel_i (erase_sel),
        .rise_o      (rise),
        .long_o      (long_low)
    );

    always_comb begin
        c_d       = c_q;
        arr_we    = 1'b0;
        arr_waddr = c_q.addr;
        arr_wdata = arr_cdata & c_q.data;
        lock_set  = '0;
        lock_clr  = 1'b0;
        unique case (c_q.st)
            ST_IDLE: begin
                if (rise && en_i && hv_i) begin
                    if (mode_i == MODE_WRITE && !prog_lock) begin
                        c_d.st   = ST_WRITE;
                        c_d.cnt  = WCNT_W'(WRITE_CYC - 1);
                        c_d.addr = addr_i;
                        c_d.data = data_i;
                    end else if (mode_i == MODE_LOCK1 || mode_i == MODE_LOCK2 ||
                                 mode_i == MODE_LOCK3) begin
                        c_d.st   = ST_LOCK;
                        c_d.cnt  = WCNT_W'(WRITE_CYC - 1);
                        c_d.lsel = (mode_i == MODE_LOCK1) ? 3'b001 :
                                   (mode_i == MODE_LOCK2) ? 3'b010 : 3'b100;
                    end else if (mode_i == MODE_ERASE && long_low) begin
                        c_d.st    = ST_ERASE;
                        c_d.sweep = '0;
                        lock_clr  = 1'b1;
                    end
                end
            end
            ST_WRITE: begin
                if (c_q.cnt == '0) begin
                    arr_we = 1'b1;
                    c_d.st = ST_IDLE;
                end else begin
                    c_d.cnt = c_q.cnt - 1'b1;
                end
            end
            ST_LOCK: begin
                if (c_q.cnt == '0) begin
                    lock_set = c_q.lsel;
                    c_d.st   = ST_IDLE;
                end else begin
                    c_d.cnt = c_q.cnt - 1'b1;
                end
            end
            ST_ERASE: begin
                arr_we    = 1'b1;
                arr_waddr = c_q.sweep;
                arr_wdata = 8'hFF;
                if (c_q.sweep == ADDR_W'(DEPTH - 1)) begin
                    c_d.st = ST_IDLE;
                end else begin
                    c_d.sweep = c_q.sweep + 1'b1;
                end
            end
            default: c_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            c_q <= '{st: ST_IDLE, default: '0};
        end else begin
            c_q <= c_d;
        end
    end

    fpc_array #(.ADDR_W(ADDR_W), .DATA_W(8)) u_array (
        .clk     (clk),
        .we_i    (arr_we),
        .waddr_i (arr_waddr),
        .wdata_i (arr_wdata),
        .raddr_i (addr_i),
        .rdata_o (arr_rdata),
        .caddr_i (c_q.addr),
        .cdata_o (arr_cdata)
    );

    fpc_lock u_lock (
        .clk           (clk),
        .rst_n         (rst_n),
        .set_i         (lock_set),
        .clr_i         (lock_clr),
        .ea_pin_i      (ea_pin_i),
        .prog_lock_o   (prog_lock),
        .verify_lock_o (verify_lock),
        .ext_exec_ok_o (ext_exec_ok_o),
        .ea_eff_o      (ea_eff_o)
    );

    fpc_readout #(.ADDR_W(ADDR_W)) u_readout (
        .clk           (clk),
        .rst_n         (rst_n),
        .en_i          (en_i),
        .hv_i          (hv_i),
        .mode_i        (mode_i),
        .addr_i        (addr_i),
        .arr_i         (arr_rdata),
        .poll_i        (c_q.st == ST_WRITE),
        .poll_addr_i   (c_q.addr),
        .poll_data_i   (c_q.data),
        .verify_lock_i (verify_lock),
        .data_o        (data_o)
    );

    assign busy_n_o = (c_q.st == ST_IDLE);

    // Checker counter: length of the current busy stretch.
    logic [31:0] blen_q;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            blen_q <= '0;
        end else if (!busy_n_o) begin
            blen_q <= blen_q + 1;
        end else begin
            blen_q <= '0;
        end
    end

    // R3: a byte write keeps the port busy for exactly WRITE_CYC cycles
    assert_busy_len_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (c_q.st == ST_IDLE && $past(c_q.st == ST_WRITE)) |-> (blen_q == 32'(WRITE_CYC)));

    // R5: a strobe seen while busy does not disturb the captured address
    assert_strobe_ignored_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (c_q.st != ST_IDLE && rise) |=> $stable(c_q.addr));

    // R9: no byte is committed while programming is locked
    assert_lock_blocks_write_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (arr_we && c_q.st == ST_WRITE) |-> !prog_lock);

    // R1: a finished erase leaves every protection level released
    assert_erase_clears_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (c_q.st == ST_ERASE && c_d.st == ST_IDLE) |=> (!prog_lock && ext_exec_ok_o && busy_n_o));
endmodule

// File: tb/flash_prog_ctrl_test.sv
`timescale 1ns/1ps
module flash_prog_ctrl_test;
    localparam int AW = 12;
    localparam int WC = 16;
    localparam int EC = 40;
    localparam int DEPTH = 1 << AW;

    localparam logic [3:0] M_SIG = 4'b0000, M_RD = 4'b0011, M_WR = 4'b0111,
                           M_ER = 4'b1000, M_L3 = 4'b1010, M_L2 = 4'b1100,
                           M_L1 = 4'b1111, M_NOP = 4'b0101;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          en_i = 1'b1;
    logic [AW-1:0] addr_i = '0;
    logic [7:0]    data_i = '0;
    logic [7:0]    data_o;
    logic [3:0]    mode_i = M_NOP;
    logic          hv_i = 1'b0;
    logic          prog_n_i = 1'b1;
    logic          ea_pin_i = 1'b1;
    logic          busy_n_o, ea_eff_o, ext_exec_ok_o;

    always #2.5 clk = ~clk;

    flash_prog_ctrl #(.ADDR_W(AW), .WRITE_CYC(WC), .ERASE_CYC(EC)) uut (
        .clk(clk), .rst_n(rst_n), .en_i(en_i), .addr_i(addr_i), .data_i(data_i),
        .data_o(data_o), .mode_i(mode_i), .hv_i(hv_i), .prog_n_i(prog_n_i),
        .ea_pin_i(ea_pin_i), .busy_n_o(busy_n_o), .ea_eff_o(ea_eff_o),
        .ext_exec_ok_o(ext_exec_ok_o)
    );

    int n_run = 0;
    int n_fail = 0;

    typedef struct {
        logic [7:0] exp;
        string      tag;
    } item_t;
    item_t sbq[$];

    task automatic check(input bit ok, input string tag,
                         input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // Monitor: compare registered read data against the scoreboard.
    initial begin
        forever begin
            @(posedge clk);
            #1;
            if (sbq.size() > 0) begin
                item_t it;
                it = sbq.pop_front();
                check(data_o === it.exp, it.tag, 32'(data_o), 32'(it.exp));
            end
        end
    end

    task automatic rd(input logic [AW-1:0] a, input logic [3:0] m,
                      input logic [7:0] exp, input string tag);
        item_t it;
        @(negedge clk);
        addr_i = a; mode_i = m; hv_i = 1'b0;
        it.exp = exp; it.tag = tag;
        sbq.push_back(it);
        @(negedge clk);
    endtask

    task automatic strobe(input logic [3:0] m, input logic hv, input logic [AW-1:0] a,
                          input logic [7:0] d, input int hold);
        @(negedge clk);
        mode_i = m; hv_i = hv; addr_i = a; data_i = d; prog_n_i = 1'b0;
        repeat (hold) @(negedge clk);
        prog_n_i = 1'b1;
        @(negedge clk);
    endtask

    task automatic wait_ready(output int n);
        n = 0;
        while (busy_n_o == 1'b0 && n < 20000) begin
            n++;
            @(negedge clk);
        end
        mode_i = M_NOP; hv_i = 1'b0;
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        n_run++;
        n_fail++;
        $display("FAIL watchdog expired");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        int n;
        repeat (3) @(negedge clk);
        check(busy_n_o === 1'b1, "R12 busy after reset", 32'(busy_n_o), 1);
        check(data_o === 8'hFF, "R12 data after reset", 32'(data_o), 32'hFF);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 full erase
        strobe(M_ER, 1'b1, '0, '0, EC + 5);
        wait_ready(n);
        check(n == DEPTH, "R1 erase busy length", 32'(n), 32'(DEPTH));
        rd(12'h000, M_RD, 8'hFF, "R1 blank low");
        rd(12'hFFF, M_RD, 8'hFF, "R1 blank high");
        check(ext_exec_ok_o === 1'b1, "R11 unlocked after erase", 32'(ext_exec_ok_o), 1);

        // R3/R4 write with polling
        strobe(M_WR, 1'b1, 12'h123, 8'h5A, 2);
        rd(12'h123, M_RD, 8'hDA, "R4 poll 5A");
        wait_ready(n);
        rd(12'h123, M_RD, 8'h5A, "R3 readback 5A");

        strobe(M_WR, 1'b1, 12'h7FF, 8'hA5, 2);
        wait_ready(n);
        check(n == WC, "R3 write busy length", 32'(n), 32'(WC));
        rd(12'h7FF, M_RD, 8'hA5, "R3 readback A5");
        strobe(M_WR, 1'b1, 12'h456, 8'hA5, 2);
        rd(12'h456, M_RD, 8'h25, "R4 poll A5");
        wait_ready(n);

        // R3 AND merge over non-blank byte
        strobe(M_WR, 1'b1, 12'h7FF, 8'h0F, 2);
        wait_ready(n);
        rd(12'h7FF, M_RD, 8'h05, "R3 and-merge");

        // R5 strobe during busy, and without hv
        strobe(M_WR, 1'b1, 12'h010, 8'h11, 2);
        strobe(M_WR, 1'b1, 12'h020, 8'h22, 2);
        wait_ready(n);
        rd(12'h020, M_RD, 8'hFF, "R5 busy strobe dropped");
        rd(12'h010, M_RD, 8'h11, "R5 first write kept");
        strobe(M_WR, 1'b0, 12'h030, 8'h00, 2);
        check(busy_n_o === 1'b1, "R5 no hv no busy", 32'(busy_n_o), 1);
        rd(12'h030, M_RD, 8'hFF, "R5 no hv no write");

        // R2 short erase
        strobe(M_ER, 1'b1, '0, '0, 10);
        check(busy_n_o === 1'b1, "R2 short erase idle", 32'(busy_n_o), 1);
        wait_ready(n);
        rd(12'h123, M_RD, 8'h5A, "R2 contents kept");

        // R6 non-read mode, R13 enable low
        rd(12'h123, M_NOP, 8'hFF, "R6 non-read mode");
        en_i = 1'b0;
        strobe(M_WR, 1'b1, 12'h040, 8'h00, 2);
        check(busy_n_o === 1'b1, "R13 disabled strobe", 32'(busy_n_o), 1);
        rd(12'h123, M_RD, 8'hFF, "R13 disabled read");
        en_i = 1'b1;
        rd(12'h040, M_RD, 8'hFF, "R13 nothing written");

        // R7 signature
        rd(12'h030, M_SIG, 8'h1E, "R7 sig 030");
        rd(12'h031, M_SIG, 8'h61, "R7 sig 031");
        rd(12'h032, M_SIG, 8'hFF, "R7 sig 032");
        rd(12'h033, M_SIG, 8'hFF, "R7 sig other");

        // R9 strap follows pin while unlocked
        @(negedge clk); ea_pin_i = 1'b0; @(negedge clk);
        check(ea_eff_o === 1'b0, "R9 strap follows low", 32'(ea_eff_o), 0);
        ea_pin_i = 1'b1; @(negedge clk);
        check(ea_eff_o === 1'b1, "R9 strap follows high", 32'(ea_eff_o), 1);

        // R8 lock bit 1
        strobe(M_L1, 1'b1, '0, '0, 2);
        wait_ready(n);
        check(n == WC, "R8 lock write busy length", 32'(n), 32'(WC));
        strobe(M_WR, 1'b1, 12'h200, 8'h00, 2);
        check(busy_n_o === 1'b1, "R9 locked write ignored", 32'(busy_n_o), 1);
        rd(12'h200, M_RD, 8'hFF, "R9 array unchanged");
        rd(12'h123, M_RD, 8'h5A, "R10 verify still open");
        @(negedge clk); ea_pin_i = 1'b0; rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1; ea_pin_i = 1'b1;
        @(negedge clk);
        check(ea_eff_o === 1'b0, "R9 strap latched at reset", 32'(ea_eff_o), 0);

        // R10 lock bit 2
        strobe(M_L2, 1'b1, '0, '0, 2);
        wait_ready(n);
        rd(12'h123, M_RD, 8'hFF, "R10 verify blanked");
        rd(12'h031, M_SIG, 8'h61, "R10 signature open");
        check(ext_exec_ok_o === 1'b1, "R11 two locks", 32'(ext_exec_ok_o), 1);

        // R11 lock bit 3
        strobe(M_L3, 1'b1, '0, '0, 2);
        wait_ready(n);
        check(ext_exec_ok_o === 1'b0, "R11 three locks", 32'(ext_exec_ok_o), 0);

        // R1 erase releases everything
        strobe(M_ER, 1'b1, '0, '0, EC);
        wait_ready(n);
        check(n == DEPTH, "R1 second erase length", 32'(n), 32'(DEPTH));
        check(ext_exec_ok_o === 1'b1, "R1 locks cleared", 32'(ext_exec_ok_o), 1);
        rd(12'h123, M_RD, 8'hFF, "R1 byte erased");
        strobe(M_WR, 1'b1, 12'h001, 8'h3C, 2);
        wait_ready(n);
        rd(12'h001, M_RD, 8'h3C, "R1 write reopened");

        repeat (2) @(negedge clk);
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule